// File: doc/BRIEF.md
# Card Clock Generator with Start/Stop/Reset Control

This block produces the card clock of an SD/MMC host. It divides its input clock by a power of two chosen by a 3-bit code, and it opens or closes the clock on host request without ever emitting a shortened high or low phase. The host writes two registers. The control register carries one-shot request bits. The divider register carries the code. The host polls a 16-bit status word to learn whether the clock is running and whether a controller reset is still in progress. A one-cycle start-operation pulse is passed on to the command engine.

The block's clock `clk` is twice the card reference frequency; a 48 MHz `clk` stands for a 24 MHz reference. A phase of the card clock lasts 2^code cycles of `clk`, so the card clock equals reference / 2^code. That gives 24 MHz at code 0 and 24 MHz / 128 at code 7, and the output is always a register.

Top module: `card_clock_gen`

## Requirements
- R1: After `rstN` is released, `cardClk` and `startOp` are low and `statusWord` is all zeros.
- R2: While running, every high phase and every low phase of `cardClk` lasts exactly 2^code cycles of `clk`, for each code 0 to 7. The code is held in `wrData[2:0]` of a divider write (`wrSel`=1).
- R3: A control write (`wrSel`=0) with bit 1 set starts a stopped clock. Status bit 8 rises in the second cycle after the accepting edge, and the first low phase has its full length.
- R4: A stop request (control bit 0) that finds the clock low halts it at once, with no further high phase.
- R5: A stop request that finds the clock high lets that high phase finish at full length and then holds the clock low. Status bit 8 stays high as long as the clock is high and is low once the clock has halted.
- R6: When bits 0 and 1 are written together, the stop wins: a stopped clock stays stopped and a running clock halts.
- R7: Control bit 2 gives a single-cycle `startOp` pulse in the cycle after the accepting edge. It does this alone or together with bit 1, and on its own it does not start the clock.
- R8: Control bit 3 sets status bit 15 for exactly 16 cycles, starting in the cycle after the accepting edge. It stops the clock cleanly, with the high phase in progress kept whole, and returns the divider code to 0.
- R9: While status bit 15 is high, all register writes (start requests and divider writes) are ignored.
- R10: A divider write made while running takes effect only at the end of the current high phase. Phases before that point keep the old length and phases after it take the new one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock, twice the card reference frequency |
| rstN | input | 1 | Asynchronous active-low reset |
| wrEn | input | 1 | Register write strobe |
| wrSel | input | 1 | 0 selects the control register, 1 selects the divider register |
| wrData | input | 4 | Write data: control bits 0..3, or divider code in bits 2..0 |
| cardClk | output | 1 | Gated, divided card clock |
| startOp | output | 1 | One-cycle start-operation pulse to the command engine |
| statusWord | output | 16 | Bit 8 clock running, bit 15 reset in progress, others zero |

## Verification
The bench sweeps all eight codes and measures each phase length against 2^code. A wrong mask or an off-by-one in the divider shows up as phases one cycle short or long. For every code it stops the clock in the middle of a high phase and just after a start. A gate that closed at the wrong moment would leave a clipped high pulse, a late extra pulse, or a running flag that drops while the clock is still high. It changes the divider in the middle of a high phase in both directions, where a design that switched at once would cut that phase short. It also probes the stop-over-start priority, the reset window length, and writes made during reset, which a careless decoder would let through by restarting the clock or keeping a stale divider.

// File: rtl/cclk_pkg.sv
package cclk_pkg;
  localparam int unsigned WDATA_W        = 4;
  localparam int unsigned STAT_W         = 16;
  localparam int unsigned CTRL_STOP_BIT  = 0;
  localparam int unsigned CTRL_START_BIT = 1;
  localparam int unsigned CTRL_OP_BIT    = 2;
  localparam int unsigned CTRL_RESET_BIT = 3;
  localparam int unsigned STAT_RUN_BIT   = 8;
  localparam int unsigned STAT_RESET_BIT = 15;

  typedef struct packed {
    logic clkStart;
    logic clkStop;
  } clk_cmd_t;
endpackage

// File: rtl/cclk_ctrl.sv
module cclk_ctrl
  import cclk_pkg::*;
#(
  parameter int unsigned CODE_W     = 3,
  parameter int unsigned RST_CYCLES = 16
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               wrEn,
  input  logic               wrSel,
  input  logic [WDATA_W-1:0] wrData,
  output clk_cmd_t           cmd,
  output logic [CODE_W-1:0]  reqCode,
  output logic               startOp,
  output logic               resetting
);
  localparam int unsigned RCNT_W = $clog2(RST_CYCLES + 1);

  logic [RCNT_W-1:0] rstCnt;
  logic accept, ctrlWr, divWr, wantReset;

  assign resetting = (rstCnt != '0);
  assign accept    = wrEn && !resetting;
  assign ctrlWr    = accept && !wrSel;
  assign divWr     = accept && wrSel;
  assign wantReset = ctrlWr && wrData[CTRL_RESET_BIT];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cmd     <= '0;
      startOp <= 1'b0;
      rstCnt  <= '0;
      reqCode <= '0;
    end else begin
      cmd.clkStop  <= ctrlWr && (wrData[CTRL_STOP_BIT] || wrData[CTRL_RESET_BIT]);
      cmd.clkStart <= ctrlWr && wrData[CTRL_START_BIT] &&
                      !wrData[CTRL_STOP_BIT] && !wrData[CTRL_RESET_BIT];
      startOp      <= ctrlWr && wrData[CTRL_OP_BIT] && !wrData[CTRL_RESET_BIT];
      if (wantReset) begin
        rstCnt  <= RCNT_W'(RST_CYCLES);
        reqCode <= '0;
      end else begin
        if (resetting) rstCnt <= rstCnt - RCNT_W'(1);
        if (divWr)     reqCode <= wrData[CODE_W-1:0];
      end
    end
  end

  // R8: entering reset always issues a clock stop
  p_reset_stops_r8: assert property (@(posedge clk) disable iff (!rstN)
    $rose(resetting) |-> cmd.clkStop);

  // R9: no start reaches the datapath while resetting
  p_no_start_in_reset_r9: assert property (@(posedge clk) disable iff (!rstN)
    resetting |-> !cmd.clkStart);

  // R7: a start-op pulse always follows a control write carrying bit 2
  p_op_pulse_r7: assert property (@(posedge clk) disable iff (!rstN)
    startOp |-> $past(wrEn && !wrSel && wrData[CTRL_OP_BIT]));
endmodule

// File: rtl/cclk_datapath.sv
module cclk_datapath
  import cclk_pkg::*;
#(
  parameter int unsigned CODE_W = 3
) (
  input  logic              clk,
  input  logic              rstN,
  input  clk_cmd_t          cmd,
  input  logic [CODE_W-1:0] reqCode,
  output logic              cardClk,
  output logic              running
);
  localparam int unsigned CNT_W = (1 << CODE_W) - 1;

  logic [CNT_W-1:0]  cnt;
  logic [CNT_W-1:0]  mask;
  logic [CODE_W-1:0] code;
  logic              stopPend, stopNow, tick;

  assign mask    = ~({CNT_W{1'b1}} << code);
  assign tick    = ((cnt & mask) == mask);
  assign stopNow = stopPend || cmd.clkStop;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cnt      <= '0;
      code     <= '0;
      cardClk  <= 1'b0;
      running  <= 1'b0;
      stopPend <= 1'b0;
    end else if (!running) begin
      cnt      <= '0;
      cardClk  <= 1'b0;
      stopPend <= 1'b0;
      code     <= reqCode;
      running  <= cmd.clkStart && !cmd.clkStop;
    end else begin
      cnt <= cnt + CNT_W'(1);
      if (stopNow && !cardClk) begin
        running  <= 1'b0;
        cnt      <= '0;
        stopPend <= 1'b0;
      end else if (tick && cardClk) begin
        cardClk  <= 1'b0;
        cnt      <= '0;
        code     <= reqCode;
        running  <= !stopNow;
        stopPend <= 1'b0;
      end else begin
        if (tick) cardClk <= 1'b1;
        stopPend <= stopNow;
      end
    end
  end

  // R5: a high level only exists while the gate is open
  p_high_only_running_r5: assert property (@(posedge clk) disable iff (!rstN)
    cardClk |-> running);

  // R4: the gate closes with the clock low
  p_halt_low_r4: assert property (@(posedge clk) disable iff (!rstN)
    $fell(running) |-> !cardClk);

  // R3: the gate opens with the clock low
  p_start_low_r3: assert property (@(posedge clk) disable iff (!rstN)
    $rose(running) |-> !cardClk);

  // R10: the applied code only changes with the clock low
  p_code_at_boundary_r10: assert property (@(posedge clk) disable iff (!rstN)
    (code != $past(code)) |-> !cardClk);
endmodule

// File: rtl/card_clock_gen.sv
module card_clock_gen
  import cclk_pkg::*;
#(
  parameter int unsigned CODE_W     = 3,
  parameter int unsigned RST_CYCLES = 16
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               wrEn,
  input  logic               wrSel,
  input  logic [WDATA_W-1:0] wrData,
  output logic               cardClk,
  output logic               startOp,
  output logic [STAT_W-1:0]  statusWord
);
  clk_cmd_t          cmd;
  logic [CODE_W-1:0] reqCode;
  logic              resetting, running;

  cclk_ctrl #(.CODE_W(CODE_W), .RST_CYCLES(RST_CYCLES)) uCtrl (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrSel(wrSel), .wrData(wrData),
    .cmd(cmd), .reqCode(reqCode), .startOp(startOp), .resetting(resetting)
  );

  cclk_datapath #(.CODE_W(CODE_W)) uPath (
    .clk(clk), .rstN(rstN), .cmd(cmd), .reqCode(reqCode),
    .cardClk(cardClk), .running(running)
  );

  always_comb begin
    statusWord = '0;
    statusWord[STAT_RUN_BIT]   = running;
    statusWord[STAT_RESET_BIT] = resetting;
  end
endmodule

// File: tb/sim_card_clock_gen.sv
module sim_card_clock_gen;
  logic clk = 1'b0;
  logic rstN, wrEn, wrSel;
  logic [3:0] wrData;
  logic cardClk, startOp;
  logic [15:0] statusWord;
  int nCmp = 0, nBad = 0;
  bit done = 0;
  int n, hi;
  bit bad;

  card_clock_gen u0 (.clk(clk), .rstN(rstN), .wrEn(wrEn), .wrSel(wrSel),
    .wrData(wrData), .cardClk(cardClk), .startOp(startOp), .statusWord(statusWord));

  always #5 clk = ~clk;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    nCmp++;
    if (!ok) begin
      nBad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic wr(input logic sel, input logic [3:0] d);
    wrEn = 1'b1; wrSel = sel; wrData = d;
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  task automatic runLen(output int len);
    logic v;
    v = cardClk; len = 0;
    while (cardClk == v && len < 1000) begin len++; @(negedge clk); end
  endtask

  task automatic summary();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nCmp, nBad);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      nBad++;
      $display("FAIL watchdog: actual 0 expected 1");
      summary();
      $finish;
    end
  end

  initial begin
    rstN = 1'b0; wrEn = 1'b0; wrSel = 1'b0; wrData = '0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    chk(cardClk == 0, "R1 cardClk", cardClk, 0);
    chk(startOp == 0, "R1 startOp", startOp, 0);
    chk(statusWord == 0, "R1 status", statusWord, 0);

    for (int k = 0; k < 8; k++) begin
      wr(1'b1, 4'(k));
      wr(1'b0, 4'h2);
      chk(statusWord[8] == 0, "R3 not yet running", statusWord[8], 0);
      @(negedge clk);
      chk(statusWord[8] == 1, "R3 running", statusWord[8], 1);
      runLen(n); chk(n == (1 << k), "R3 first low", n, 1 << k);
      runLen(n); chk(n == (1 << k), "R2 high", n, 1 << k);
      runLen(n); chk(n == (1 << k), "R2 low", n, 1 << k);
      // stop while high (R5)
      bad = 0;
      if (!statusWord[8]) bad = 1;
      wr(1'b0, 4'h1);
      n = 1;
      while (cardClk && n < 1000) begin
        if (!statusWord[8]) bad = 1;
        n++; @(negedge clk);
      end
      chk(n == (1 << k), "R5 high kept whole", n, 1 << k);
      chk(!bad, "R5 flag high during high", bad, 0);
      @(negedge clk);
      chk(statusWord[8] == 0, "R5 halted flag", statusWord[8], 0);
      bad = 0;
      for (int c = 0; c < (2 << k) + 2; c++) begin
        if (cardClk) bad = 1;
        @(negedge clk);
      end
      chk(!bad, "R5 stays low", bad, 0);
      // stop while low (R4)
      if (k >= 1) begin
        wr(1'b0, 4'h2);
        @(negedge clk);
        wr(1'b0, 4'h1);
        bad = 0;
        for (int c = 0; c < (2 << k); c++) begin
          if (cardClk) bad = 1;
          @(negedge clk);
        end
        chk(!bad, "R4 no high after stop", bad, 0);
        chk(statusWord[8] == 0, "R4 halted", statusWord[8], 0);
      end
    end

    // R6 stop wins
    wr(1'b0, 4'h3);
    repeat (3) @(negedge clk);
    chk(statusWord[8] == 0 && cardClk == 0, "R6 stopped stays", statusWord[8], 0);
    wr(1'b1, 4'h0);
    wr(1'b0, 4'h2);
    @(negedge clk);
    chk(statusWord[8] == 1, "R6 precondition run", statusWord[8], 1);
    wr(1'b0, 4'h3);
    repeat (3) @(negedge clk);
    chk(statusWord[8] == 0, "R6 running halts", statusWord[8], 0);

    // R7 start-op pulse
    wr(1'b0, 4'h4);
    chk(startOp == 1, "R7 pulse", startOp, 1);
    @(negedge clk);
    chk(startOp == 0, "R7 one cycle", startOp, 0);
    chk(statusWord[8] == 0, "R7 no start", statusWord[8], 0);
    wr(1'b0, 4'h6);
    chk(startOp == 1, "R7 pulse with start", startOp, 1);
    @(negedge clk);
    chk(startOp == 0 && statusWord[8] == 1, "R7 pulse ends, clock runs", startOp, 0);
    wr(1'b0, 4'h1);
    repeat (3) @(negedge clk);

    // R10 divider change at boundary, 2 -> 1
    wr(1'b1, 4'd2);
    wr(1'b0, 4'h2);
    @(negedge clk);
    runLen(n);
    wr(1'b1, 4'd1);
    n = 1;
    while (cardClk && n < 1000) begin n++; @(negedge clk); end
    chk(n == 4, "R10 old high", n, 4);
    runLen(n); chk(n == 2, "R10 new low", n, 2);
    runLen(n); chk(n == 2, "R10 new high", n, 2);
    // 1 -> 3
    runLen(n);
    wr(1'b1, 4'd3);
    n = 1;
    while (cardClk && n < 1000) begin n++; @(negedge clk); end
    chk(n == 2, "R10 old high b", n, 2);
    runLen(n); chk(n == 8, "R10 new low b", n, 8);
    runLen(n); chk(n == 8, "R10 new high b", n, 8);

    // R8 reset while high, code 3
    runLen(n);
    wr(1'b0, 4'h8);
    n = 0; hi = 0;
    while (statusWord[15] && n < 1000) begin
      if (cardClk) hi++;
      n++; @(negedge clk);
    end
    chk(n == 16, "R8 reset window", n, 16);
    chk(1 + hi == 8, "R8 high kept whole", 1 + hi, 8);
    chk(statusWord[8] == 0 && cardClk == 0, "R8 halted", statusWord[8], 0);

    // R9 writes during reset ignored; R8 divider back to 0
    wr(1'b0, 4'h8);
    wr(1'b0, 4'h2);
    wr(1'b1, 4'd5);
    while (statusWord[15]) @(negedge clk);
    repeat (3) @(negedge clk);
    chk(statusWord[8] == 0, "R9 start ignored", statusWord[8], 0);
    wr(1'b0, 4'h2);
    @(negedge clk);
    runLen(n); chk(n == 1, "R9 divider write ignored, R8 code 0 low", n, 1);
    runLen(n); chk(n == 1, "R8 code 0 high", n, 1);

    done = 1;
    summary();
    $finish;
  end
endmodule